// File: doc/BRIEF.md
# NAND Flash Device Command Decoder Model

This block is a synthesizable, device-side stand-in for a NAND flash part, meant to sit on the far side of a flash controller in a testbench or emulation build. It samples the multiplexed 8-bit bus and its strobes on a system clock. A rising edge of the write strobe with chip select low latches one bus cycle. That cycle is a command byte when the command-latch input is high, an address byte when the address-latch input is high, and a data byte when both are low. A falling edge of the read strobe hands out the next byte.

Command pairs start a page read, a page load and program, a block erase, and a column redirect for output or input. Single-cycle commands return status, return an identifier, or reset the model. Each busy operation holds the ready output low for a fixed number of clocks set by a parameter. A single page register of main plus spare bytes takes the place of the cell array. Reads return its contents, loads write into it, and an erase fills it with FFh one byte per clock while busy. Row address bytes are counted but do not select anything.

Top module: `nand_cmd_model`

## Requirements
- R1: After reset `ready` is 1, `bus_oe` is 0 and the status fail bit is 0. The read setup (00h) counts as already latched, so five address cycles and then 30h start a read.
- R2: Command 30h after 00h and address cycles holds `ready` at 0 for exactly READ_CYC clocks. After that, successive read-strobe pulses return the page bytes from the loaded column upward.
- R3: The column counter stops at the last column (PAGE_BYTES-1, 2111 by default). Further read pulses there return the same byte again.
- R4: Address cycles beyond the count a command needs (5 for read or program, 2 for a column redirect, 3 for erase, 1 for ID) are ignored. The first address byte is column bits 7:0 and the low bits of the second are column bits 11:8.
- R5: 05h, then two column address cycles, then E0h moves the output column within the page. This may be repeated any number of times.
- R6: 80h with five address cycles opens a page load. Each data cycle writes the byte at the current column and advances it. 85h with two column cycles redirects the load column. 10h then holds `ready` at 0 for PROG_CYC clocks and clears the fail bit.
- R7: 60h, three row cycles and D0h hold `ready` at 0 for max(ERASE_CYC, PAGE_BYTES) clocks, clear the fail bit, and leave every page byte at FFh.
- R8: After 70h, a read pulse returns the status byte. Bit 7 is the write-protect input (1 means writable), bits 6 and 5 are 1 when ready, bit 0 is the fail bit, and all other bits are 0. 70h is also accepted while busy. 00h or E0h returns the output to page data.
- R9: While busy, every command except 70h and FFh is ignored, and so are all address and data cycles.
- R10: FFh, whether busy or ready, holds `ready` at 0 for RST_CYC clocks, aborts an erase, and restores the latched read setup.
- R11: With `wr_prot_n` low, data cycles do not write the page, and a 10h or D0h confirm sets the fail bit without going busy.
- R12: `bus_oe` is 1 only while chip select and the read strobe are both low and neither latch input is high.
- R13: After 90h and one address cycle, read pulses return ID_FIRST, then ID_SECOND, then 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than any strobe |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| cmd_latch | input | 1 | Marks a write cycle as a command byte |
| addr_latch | input | 1 | Marks a write cycle as an address byte |
| wr_strobe_n | input | 1 | Write strobe; the bus is latched on its rising edge |
| rd_strobe_n | input | 1 | Read strobe; each falling edge serves one byte |
| wr_prot_n | input | 1 | Write protect, active low |
| bus_in | input | 8 | Bus value driven by the controller |
| bus_out | output | 8 | Byte served by the model |
| bus_oe | output | 1 | Output enable for `bus_out` |
| ready | output | 1 | 1 when ready, 0 while busy |

## Verification
The assertions assume that the controller holds each strobe level for at least one clock, so every edge is seen once. They also assume the bus and latch inputs stay stable across the sampled write edge, and that a read pulse never coincides with a write pulse. The bench keeps to this by changing every input on the falling clock edge only. Each strobe level lasts a full clock, and the latch inputs and the bus are released one clock after the write strobe rises. Read and write pulses are issued strictly one after the other.

// File: rtl/nand_model_pkg.sv
package nand_model_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_SETUP,
        PH_PG_SETUP,
        PH_ER_SETUP,
        PH_RO_SETUP,
        PH_ID_SETUP
    } phase_e;

    typedef enum logic [1:0] {
        OUT_DATA,
        OUT_STATUS,
        OUT_ID
    } outsel_e;

    typedef struct packed {
        logic       cmd;
        logic       addr;
        logic       data;
        logic [7:0] val;
    } bus_cycle_t;

    localparam logic [7:0] OP_RD_SETUP = 8'h00;
    localparam logic [7:0] OP_RD_GO    = 8'h30;
    localparam logic [7:0] OP_PG_SETUP = 8'h80;
    localparam logic [7:0] OP_PG_GO    = 8'h10;
    localparam logic [7:0] OP_RI_SETUP = 8'h85;
    localparam logic [7:0] OP_ER_SETUP = 8'h60;
    localparam logic [7:0] OP_ER_GO    = 8'hD0;
    localparam logic [7:0] OP_RO_SETUP = 8'h05;
    localparam logic [7:0] OP_RO_GO    = 8'hE0;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_RESET    = 8'hFF;

    function automatic logic [7:0] status_byte(logic writable, logic rdy, logic fail);
        return {writable, rdy, rdy, 4'b0000, fail};
    endfunction

endpackage

// File: rtl/nand_pin_sampler.sv
module nand_pin_sampler
    import nand_model_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_sel_n,
    input  logic       cmd_latch,
    input  logic       addr_latch,
    input  logic       wr_strobe_n,
    input  logic       rd_strobe_n,
    input  logic [7:0] bus_in,
    output logic       we_rise,
    output logic       re_fall,
    output bus_cycle_t cyc
);
    logic wr_q;
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_strobe_n;
            rd_q <= rd_strobe_n;
        end
    end

    assign we_rise  = ~wr_q & wr_strobe_n & ~chip_sel_n;
    assign re_fall  = rd_q & ~rd_strobe_n & ~chip_sel_n;
    assign cyc.cmd  = cmd_latch & ~addr_latch;
    assign cyc.addr = addr_latch & ~cmd_latch;
    assign cyc.data = ~cmd_latch & ~addr_latch;
    assign cyc.val  = bus_in;
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
    parameter int DEPTH = 2112,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'hFF;
endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
    import nand_model_pkg::*;
#(
    parameter int          PAGE_BYTES = 2112,
    parameter int          READ_CYC   = 25,
    parameter int          PROG_CYC   = 40,
    parameter int          ERASE_CYC  = 2200,
    parameter int          RST_CYC    = 8,
    parameter logic [7:0]  ID_FIRST   = 8'hA5,
    parameter logic [7:0]  ID_SECOND  = 8'h5A,
    parameter int          CW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_rise,
    input  logic          re_fall,
    input  bus_cycle_t    cyc,
    input  logic          wr_prot_n,
    input  logic [7:0]    rd_data,
    output logic [CW-1:0] col,
    output logic          wr_en,
    output logic [CW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [7:0]    dout,
    output logic          ready
);
    localparam logic [CW-1:0] LAST_COL = CW'(PAGE_BYTES - 1);
    localparam int ERASE_LEN = (ERASE_CYC > PAGE_BYTES) ? ERASE_CYC : PAGE_BYTES;
    localparam int MAX_A     = (READ_CYC > PROG_CYC) ? READ_CYC : PROG_CYC;
    localparam int MAX_B     = (ERASE_LEN > RST_CYC) ? ERASE_LEN : RST_CYC;
    localparam int MAX_BUSY  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int BW        = $clog2(MAX_BUSY + 1);

    phase_e        phase;
    outsel_e       out_sel;
    logic [2:0]    addr_cnt;
    logic [2:0]    addr_need;
    logic [BW-1:0] busy_cnt;
    logic          erasing;
    logic [CW-1:0] erase_ptr;
    logic          fail;
    logic [1:0]    id_idx;
    logic          is_cmd, is_addr, is_data, data_ok;
    logic [CW-1:0] col_next;

    always_comb begin
        ready    = (busy_cnt == '0);
        is_cmd   = we_rise & cyc.cmd;
        is_addr  = we_rise & cyc.addr & ready;
        is_data  = we_rise & cyc.data & ready;
        col_next = (col >= LAST_COL) ? col : col + 1'b1;
        data_ok  = is_data && (phase == PH_PG_SETUP) && (addr_cnt >= addr_need) && wr_prot_n;
        wr_en    = erasing | data_ok;
        wr_addr  = erasing ? erase_ptr : col;
        wr_data  = erasing ? 8'hFF : cyc.val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_RD_SETUP;
            out_sel   <= OUT_DATA;
            col       <= '0;
            addr_cnt  <= '0;
            addr_need <= 3'd5;
            busy_cnt  <= '0;
            erasing   <= 1'b0;
            erase_ptr <= '0;
            fail      <= 1'b0;
            id_idx    <= '0;
            dout      <= '0;
        end else begin
            if (!ready) busy_cnt <= busy_cnt - 1'b1;
            if (erasing) begin
                if (erase_ptr == LAST_COL) erasing <= 1'b0;
                else erase_ptr <= erase_ptr + 1'b1;
            end

            if (is_cmd) begin
                if (cyc.val == OP_RESET) begin
                    busy_cnt  <= BW'(RST_CYC);
                    erasing   <= 1'b0;
                    phase     <= PH_RD_SETUP;
                    out_sel   <= OUT_DATA;
                    addr_cnt  <= '0;
                    addr_need <= 3'd5;
                end else if (cyc.val == OP_STATUS) begin
                    out_sel <= OUT_STATUS;
                end else if (ready) begin
                    case (cyc.val)
                        OP_RD_SETUP: begin
                            phase <= PH_RD_SETUP; addr_cnt <= '0; addr_need <= 3'd5;
                            out_sel <= OUT_DATA;
                        end
                        OP_RD_GO: if (phase == PH_RD_SETUP) begin
                            busy_cnt <= BW'(READ_CYC); phase <= PH_IDLE; out_sel <= OUT_DATA;
                        end
                        OP_PG_SETUP: begin
                            phase <= PH_PG_SETUP; addr_cnt <= '0; addr_need <= 3'd5;
                        end
                        OP_RI_SETUP: if (phase == PH_PG_SETUP) begin
                            addr_cnt <= '0; addr_need <= 3'd2;
                        end
                        OP_PG_GO: if (phase == PH_PG_SETUP) begin
                            phase <= PH_IDLE;
                            if (!wr_prot_n) fail <= 1'b1;
                            else begin fail <= 1'b0; busy_cnt <= BW'(PROG_CYC); end
                        end
                        OP_ER_SETUP: begin
                            phase <= PH_ER_SETUP; addr_cnt <= '0; addr_need <= 3'd3;
                        end
                        OP_ER_GO: if (phase == PH_ER_SETUP) begin
                            phase <= PH_IDLE;
                            if (!wr_prot_n) fail <= 1'b1;
                            else begin
                                fail <= 1'b0; busy_cnt <= BW'(ERASE_LEN);
                                erasing <= 1'b1; erase_ptr <= '0;
                            end
                        end
                        OP_RO_SETUP: begin
                            phase <= PH_RO_SETUP; addr_cnt <= '0; addr_need <= 3'd2;
                        end
                        OP_RO_GO: if (phase == PH_RO_SETUP) begin
                            phase <= PH_IDLE; out_sel <= OUT_DATA;
                        end
                        OP_IDENT: begin
                            phase <= PH_ID_SETUP; addr_cnt <= '0; addr_need <= 3'd1;
                            out_sel <= OUT_ID; id_idx <= '0;
                        end
                        default: ;
                    endcase
                end
            end

            if (is_addr && (addr_cnt < addr_need)) begin
                addr_cnt <= addr_cnt + 1'b1;
                if (phase != PH_ER_SETUP && phase != PH_ID_SETUP) begin
                    if (addr_cnt == 3'd0) col[7:0] <= cyc.val;
                    else if (addr_cnt == 3'd1) col[CW-1:8] <= cyc.val[CW-9:0];
                end
            end

            if (data_ok) col <= col_next;

            if (re_fall) begin
                case (out_sel)
                    OUT_STATUS: dout <= status_byte(wr_prot_n, ready, fail);
                    OUT_ID: begin
                        dout <= (id_idx == 2'd0) ? ID_FIRST :
                                (id_idx == 2'd1) ? ID_SECOND : 8'h00;
                        if (id_idx != 2'd2) id_idx <= id_idx + 1'b1;
                    end
                    default: if (ready) begin
                        dout <= rd_data;
                        col  <= col_next;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/nand_cmd_model.sv
module nand_cmd_model
    import nand_model_pkg::*;
#(
    parameter int          MAIN_BYTES  = 2048,
    parameter int          SPARE_BYTES = 64,
    parameter int          READ_CYC    = 25,
    parameter int          PROG_CYC    = 40,
    parameter int          ERASE_CYC   = 2200,
    parameter int          RST_CYC     = 8,
    parameter logic [7:0]  ID_FIRST    = 8'hA5,
    parameter logic [7:0]  ID_SECOND   = 8'h5A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_sel_n,
    input  logic       cmd_latch,
    input  logic       addr_latch,
    input  logic       wr_strobe_n,
    input  logic       rd_strobe_n,
    input  logic       wr_prot_n,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       ready
);
    localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
    localparam int COL_W      = $clog2(PAGE_BYTES);

    logic             we_rise;
    logic             re_fall;
    bus_cycle_t       cyc;
    logic [COL_W-1:0] col_ptr;
    logic             wr_en;
    logic [COL_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    nand_pin_sampler u_pins (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch),
        .addr_latch(addr_latch), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
        .bus_in(bus_in), .we_rise(we_rise), .re_fall(re_fall), .cyc(cyc)
    );

    nand_cmd_ctrl #(
        .PAGE_BYTES(PAGE_BYTES), .READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .RST_CYC(RST_CYC), .ID_FIRST(ID_FIRST),
        .ID_SECOND(ID_SECOND), .CW(COL_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .we_rise(we_rise), .re_fall(re_fall), .cyc(cyc),
        .wr_prot_n(wr_prot_n), .rd_data(rd_data), .col(col_ptr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dout(bus_out), .ready(ready)
    );

    nand_page_buf #(.DEPTH(PAGE_BYTES), .AW(COL_W)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(col_ptr), .rd_data(rd_data)
    );

    assign bus_oe = ~chip_sel_n & ~rd_strobe_n & ~cmd_latch & ~addr_latch;
endmodule

// File: rtl/nand_cmd_model_chk.sv
module nand_cmd_model_chk (
    input logic        clk,
    input logic        rst,
    input logic        we_rise,
    input logic        re_fall,
    input logic        is_cmd,
    input logic        is_data,
    input logic [7:0]  cyc_val,
    input logic        wr_prot_n,
    input logic        ready,
    input logic        bus_oe,
    input logic        cmd_latch,
    input logic        addr_latch,
    input logic        chip_sel_n,
    input logic [15:0] col
);
    // R9
    busy_data_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && we_rise && is_data && !re_fall) |=> $stable(col));

    // R11
    protect_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && we_rise && is_cmd && !wr_prot_n && (cyc_val == 8'h10 || cyc_val == 8'hD0))
        |=> ready);

    // R2
    busy_from_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(we_rise && is_cmd));

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (re_fall && !we_rise) |=> (col == $past(col) || col == $past(col) + 16'd1));

    // R12
    oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_latch || addr_latch || chip_sel_n) |-> !bus_oe);

    // R10
    reset_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (we_rise && is_cmd && cyc_val == 8'hFF) |=> !ready);
endmodule

bind nand_cmd_model nand_cmd_model_chk u_chk (
    .clk(clk), .rst(rst), .we_rise(we_rise), .re_fall(re_fall),
    .is_cmd(cyc.cmd), .is_data(cyc.data), .cyc_val(cyc.val),
    .wr_prot_n(wr_prot_n), .ready(ready), .bus_oe(bus_oe),
    .cmd_latch(cmd_latch), .addr_latch(addr_latch), .chip_sel_n(chip_sel_n),
    .col(16'(col_ptr))
);

// File: tb/nand_cmd_model_test.sv
module nand_cmd_model_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_sel_n = 1'b0;
    logic       cmd_latch = 1'b0;
    logic       addr_latch = 1'b0;
    logic       wr_strobe_n = 1'b1;
    logic       rd_strobe_n = 1'b1;
    logic       wr_prot_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       ready;

    int checks = 0;
    int errors = 0;

    localparam int READ_N  = 25;
    localparam int PROG_N  = 40;
    localparam int ERASE_N = 2200;
    localparam int RST_N   = 8;

    always #10 clk = ~clk;

    nand_cmd_model uut (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch),
        .addr_latch(addr_latch), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
        .wr_prot_n(wr_prot_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ready(ready)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic pulse_we(input logic c, input logic a, input logic [7:0] v);
        @(negedge clk);
        cmd_latch = c; addr_latch = a; bus_in = v; wr_strobe_n = 1'b0;
        @(negedge clk);
        wr_strobe_n = 1'b1;
        @(negedge clk);
        cmd_latch = 1'b0; addr_latch = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] v);  pulse_we(1'b1, 1'b0, v); endtask
    task automatic addr(input logic [7:0] v); pulse_we(1'b0, 1'b1, v); endtask
    task automatic data(input logic [7:0] v); pulse_we(1'b0, 1'b0, v); endtask

    task automatic addr5(input logic [11:0] c);
        addr(c[7:0]); addr({4'h0, c[11:8]}); addr(8'h00); addr(8'h00); addr(8'h00);
    endtask

    task automatic rd(output logic [7:0] v, output logic oe);
        @(negedge clk);
        rd_strobe_n = 1'b0;
        @(negedge clk);
        v = bus_out; oe = bus_oe;
        rd_strobe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_page(input logic [11:0] c);
        int n;
        cmd(8'h00); addr5(c); cmd(8'h30); wait_ready(n);
    endtask

    task automatic t_reset;
        logic [7:0] v; logic oe;
        check("R1 ready after reset", ready, 1);
        check("R1 oe after reset", bus_oe, 0);
        cmd(8'h70); rd(v, oe);
        check("R1 status after reset", v, 8'hE0);
    endtask

    task automatic t_program;
        logic [7:0] v; logic oe; int n;
        cmd(8'h80); addr5(12'h005);
        data(8'hA0); data(8'hA1); data(8'hA2); data(8'hA3);
        cmd(8'h85); addr(8'h3E); addr(8'h08);
        data(8'h66); data(8'h77);
        cmd(8'h10);
        check("R6 busy after program confirm", ready, 0);
        wait_ready(n);
        check("R6 program busy clocks", n, PROG_N);
        cmd(8'h70); rd(v, oe);
        check("R6 status after program", v, 8'hE0);
    endtask

    task automatic t_powerup_read;
        logic [7:0] v; logic oe; int n;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        addr5(12'h005); cmd(8'h30);
        check("R1 read starts without 00h", ready, 0);
        wait_ready(n);
        check("R2 read busy clocks", n, READ_N);
        rd(v, oe); check("R2 byte col5", v, 8'hA0);
        check("R12 oe during read pulse", oe, 1);
        rd(v, oe); check("R2 byte col6", v, 8'hA1);
        rd(v, oe); check("R2 byte col7", v, 8'hA2);
        rd(v, oe); check("R2 byte col8", v, 8'hA3);
    endtask

    task automatic t_surplus_clamp;
        logic [7:0] v; logic oe; int n;
        cmd(8'h00);
        addr(8'h3E); addr(8'h08); addr(8'h00); addr(8'h00); addr(8'h00);
        addr(8'h05); addr(8'h00);
        cmd(8'h30); wait_ready(n);
        rd(v, oe); check("R4 surplus address ignored", v, 8'h66);
        rd(v, oe); check("R3 last column byte", v, 8'h77);
        rd(v, oe); check("R3 column held at last", v, 8'h77);
        rd(v, oe); check("R3 column still held", v, 8'h77);
    endtask

    task automatic t_random_out;
        logic [7:0] v; logic oe;
        cmd(8'h05); addr(8'h06); addr(8'h00); cmd(8'hE0);
        rd(v, oe); check("R5 redirect to col6", v, 8'hA1);
        rd(v, oe); check("R5 continue col7", v, 8'hA2);
        cmd(8'h05); addr(8'h3F); addr(8'h08); cmd(8'hE0);
        rd(v, oe); check("R5 second redirect", v, 8'h77);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v; logic oe; int n;
        cmd(8'h00); addr5(12'h005); cmd(8'h30);
        cmd(8'h70); rd(v, oe);
        check("R8 status while busy", v, 8'h80);
        cmd(8'h05); addr(8'h08); addr(8'h00); cmd(8'hE0);
        data(8'h99);
        check("R9 still busy after ignored cycles", ready, 0);
        wait_ready(n);
        cmd(8'h00);
        rd(v, oe); check("R9 redirect ignored while busy", v, 8'hA0);
        rd(v, oe); check("R9 data cycle ignored while busy", v, 8'hA1);
    endtask

    task automatic t_soft_reset;
        logic [7:0] v; logic oe; int n;
        cmd(8'hFF);
        wait_ready(n);
        check("R10 reset busy clocks", n, RST_N);
        addr5(12'h006); cmd(8'h30);
        check("R10 read setup restored", ready, 0);
        wait_ready(n);
        rd(v, oe); check("R10 read after reset", v, 8'hA1);
    endtask

    task automatic t_id;
        logic [7:0] v; logic oe;
        cmd(8'h90); addr(8'h00);
        rd(v, oe); check("R13 first id byte", v, 8'hA5);
        rd(v, oe); check("R13 second id byte", v, 8'h5A);
        rd(v, oe); check("R13 trailing id byte", v, 8'h00);
    endtask

    task automatic t_protect;
        logic [7:0] v; logic oe;
        wr_prot_n = 1'b0;
        cmd(8'h80); addr5(12'h005); data(8'h11); cmd(8'h10);
        check("R11 program confirm no busy", ready, 1);
        cmd(8'h70); rd(v, oe);
        check("R11 status after protected program", v, 8'h61);
        cmd(8'h60); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'hD0);
        check("R11 erase confirm no busy", ready, 1);
        read_page(12'h005);
        rd(v, oe); check("R11 protected data discarded", v, 8'hA0);
        wr_prot_n = 1'b1;
    endtask

    task automatic t_erase;
        logic [7:0] v; logic oe; int n;
        cmd(8'h60); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'hD0);
        wait_ready(n);
        check("R7 erase busy clocks", n, ERASE_N);
        cmd(8'h70); rd(v, oe);
        check("R7 status after erase", v, 8'hE0);
        read_page(12'h005);
        rd(v, oe); check("R7 erased col5", v, 8'hFF);
        cmd(8'h05); addr(8'h3F); addr(8'h08); cmd(8'hE0);
        rd(v, oe); check("R7 erased last col", v, 8'hFF);
    endtask

    task automatic t_oe;
        @(negedge clk); chip_sel_n = 1'b1; rd_strobe_n = 1'b0;
        @(negedge clk); check("R12 oe off when deselected", bus_oe, 0);
        rd_strobe_n = 1'b1;
        @(negedge clk); chip_sel_n = 1'b0; cmd_latch = 1'b1; rd_strobe_n = 1'b0;
        @(negedge clk); check("R12 oe off in command phase", bus_oe, 0);
        cmd_latch = 1'b0; addr_latch = 1'b1;
        @(negedge clk); check("R12 oe off in address phase", bus_oe, 0);
        addr_latch = 1'b0;
        @(negedge clk); check("R12 oe on in data out", bus_oe, 1);
        rd_strobe_n = 1'b1;
        @(negedge clk); check("R12 oe off after pulse", bus_oe, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_program;
        t_powerup_read;
        t_surplus_clamp;
        t_random_out;
        t_busy_ignore;
        t_soft_reset;
        t_id;
        t_protect;
        t_erase;
        t_oe;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule